// File: doc/BRIEF.md
# Masked Bank Address Decoder

This block sits in the address path of a memory controller and tells which of its logical banks, if any, claims a physical address. Each bank has a decode register. The register holds an enable bit and two pairs of match and mask fields. One pair is compared against an upper slice of the address and the other against a lower slice. A set mask bit means the matching address bit is not compared. An address belongs to a bank when the bank is enabled and both slices agree outside their masked bits.

Software or a configuration engine loads the registers through a single write port. A lookup is started by raising `lkp_vld` with an address. On the next clock edge the block returns its answer: hit or miss, the local bank index, and a global bank number formed from the controller's port number. For the claiming bank it also returns three derived values. The first is the interleave factor, which the lower mask encodes. The second is the bank's base address. The third is the bank's size, which comes from the upper mask and is divided by the interleave factor.

Top module: `bank_decode`

## Requirements
- R1: After reset every bank is disabled and `res_vld` and `res_hit` are low. Any lookup made before a register is written therefore misses.
- R2: A bank whose enable bit (`cfg_data[30]`) is 0 never claims an address, whatever its match and mask fields hold.
- R3: The upper slice is address bits [42:32]. It matches when every bit that differs from the upper match field (`cfg_data[29:19]`) has its upper mask bit (`cfg_data[18:8]`) set.
- R4: The lower slice is address bits [9:6]. It is compared in the same way against the lower match field (`cfg_data[7:4]`) and the lower mask field (`cfg_data[3:0]`). A bank claims the address only when both slices match.
- R5: When several enabled banks match, the one with the lowest index is reported.
- R6: `res_ilv` is decoded from the lower mask as follows: 0xF gives 1, 0xE gives 2, 0xC gives 4, 0x8 gives 8 and 0x0 gives 16. Every other mask value gives 1.
- R7: `res_base` equals the upper match field with the upper-mask bits cleared, shifted left by 32.
- R8: `res_size` is computed from upper mask bits [9:0] only: that value plus one, shifted left by 32, then divided by the interleave factor. Upper mask bit 10 has no effect on the size.
- R9: On a hit, `res_gid` equals four times `port_id` plus the bank index.
- R10: The lookup result appears on the clock edge that follows the cycle in which `lkp_vld` is high. `res_vld` is high only in that cycle. While no lookup is made, all result fields keep their values. On a miss, `res_bank`, `res_gid`, `res_ilv`, `res_base` and `res_size` are 0.
- R11: A register write and a lookup made in the same cycle are independent: the lookup is decoded with the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_id | input | 5 | Controller port number, used to form the global bank number |
| cfg_we | input | 1 | Write strobe for a decode register |
| cfg_idx | input | 2 | Index of the register being written |
| cfg_data | input | 31 | Register value: {enable, upper match, upper mask, lower match, lower mask} |
| lkp_vld | input | 1 | Lookup strobe |
| lkp_addr | input | 43 | Physical address to decode |
| res_vld | output | 1 | Result valid, one cycle after `lkp_vld` |
| res_hit | output | 1 | High when some bank claims the address |
| res_bank | output | 2 | Local index of the claiming bank |
| res_gid | output | 7 | Global bank number |
| res_ilv | output | 5 | Interleave factor of the claiming bank |
| res_base | output | 43 | Base address of the claiming bank |
| res_size | output | 43 | Size of the claiming bank in bytes |

## Verification
The assertions assume that `lkp_vld`, `cfg_we` and `port_id` are never unknown after reset. They also assume that `port_id` stays the same between a lookup and its result, because they compare `res_gid` with the port number that is current. The stimulus changes inputs only on falling edges. It changes `port_id` only during idle cycles, and a lookup always follows at a later cycle. It uses address and register values that satisfy every slice and mask boundary, both with chosen patterns and with random ones.

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int PA_W   = 43,
  parameter int UP_LO  = 32,
  parameter int UP_W   = 11,
  parameter int LO_LO  = 6,
  parameter int LO_W   = 4,
  parameter int SZ_W   = 10,
  parameter int NBANK  = 4,
  parameter int PORT_W = 5,
  localparam int IDX_W = $clog2(NBANK),
  localparam int REG_W = 1 + 2*UP_W + 2*LO_W,
  localparam int ILV_W = LO_W + 1,
  localparam int GID_W = PORT_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_id,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [REG_W-1:0]  cfg_data,
  input  logic              lkp_vld,
  input  logic [PA_W-1:0]   lkp_addr,
  output logic              res_vld,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_bank,
  output logic [GID_W-1:0]  res_gid,
  output logic [ILV_W-1:0]  res_ilv,
  output logic [PA_W-1:0]   res_base,
  output logic [PA_W-1:0]   res_size
);
  localparam int LK_O = 0;
  localparam int LM_O = LO_W;
  localparam int UK_O = 2*LO_W;
  localparam int UM_O = 2*LO_W + UP_W;
  localparam int EN_O = REG_W - 1;
  localparam int ZW   = $clog2(LO_W + 1);

  function automatic logic [ZW-1:0] ilv_log(input logic [LO_W-1:0] m);
    ilv_log = '0;
    for (int z = 0; z <= LO_W; z++)
      if (m == LO_W'(~((1 << z) - 1))) ilv_log = ZW'(z);
  endfunction

  logic [REG_W-1:0] bank_q [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
    end else if (cfg_we) begin
      bank_q[cfg_idx] <= cfg_data;
    end
  end

  wire [UP_W-1:0] a_up = lkp_addr[UP_LO +: UP_W];
  wire [LO_W-1:0] a_lo = lkp_addr[LO_LO +: LO_W];

  logic [NBANK-1:0] match;
  logic [ZW-1:0]    zl   [NBANK];
  logic [PA_W-1:0]  base [NBANK];
  logic [PA_W-1:0]  size [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wire            en = bank_q[b][EN_O];
    wire [UP_W-1:0] um = bank_q[b][UM_O +: UP_W];
    wire [UP_W-1:0] uk = bank_q[b][UK_O +: UP_W];
    wire [LO_W-1:0] lm = bank_q[b][LM_O +: LO_W];
    wire [LO_W-1:0] lk = bank_q[b][LK_O +: LO_W];
    wire [PA_W-1:0] span = (PA_W'(uk[SZ_W-1:0]) + PA_W'(1)) << UP_LO;

    assign match[b] = en && (((a_up ^ um) & ~uk) == '0) && (((a_lo ^ lm) & ~lk) == '0);
    assign zl[b]    = ilv_log(lk);
    assign base[b]  = PA_W'(um & ~uk) << UP_LO;
    assign size[b]  = span >> zl[b];
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int b = NBANK - 1; b >= 0; b--)
      if (match[b]) sel = IDX_W'(b);
  end

  wire any = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_hit  <= 1'b0;
      res_bank <= '0;
      res_gid  <= '0;
      res_ilv  <= '0;
      res_base <= '0;
      res_size <= '0;
    end else begin
      res_vld <= lkp_vld;
      if (lkp_vld) begin
        res_hit  <= any;
        res_bank <= any ? sel : '0;
        res_gid  <= any ? {port_id, sel} : '0;
        res_ilv  <= any ? ILV_W'(1) << zl[sel] : '0;
        res_base <= any ? base[sel] : '0;
        res_size <= any ? size[sel] : '0;
      end
    end
  end
endmodule

// File: rtl/bank_decode_chk.sv
module bank_decode_chk #(
  parameter int IDX_W  = 2,
  parameter int GID_W  = 7,
  parameter int ILV_W  = 5,
  parameter int PA_W   = 43,
  parameter int PORT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PORT_W-1:0] port_id,
  input logic             lkp_vld,
  input logic             res_vld,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_bank,
  input logic [GID_W-1:0] res_gid,
  input logic [ILV_W-1:0] res_ilv,
  input logic [PA_W-1:0]  res_size
);
  p_vld_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_vld |=> res_vld);
  p_vld_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_vld |=> !res_vld);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_vld |=> $stable(res_hit) && $stable(res_bank) && $stable(res_size));
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> (res_bank == '0 && res_gid == '0 && res_ilv == '0 && res_size == '0));
  p_ilv_pow2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit) |-> $countones(res_ilv) == 1);
  p_gid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit && $stable(port_id)) |-> res_gid == {port_id, res_bank});
endmodule

bind bank_decode bank_decode_chk #(
  .IDX_W(IDX_W), .GID_W(GID_W), .ILV_W(ILV_W), .PA_W(PA_W), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_id(port_id), .lkp_vld(lkp_vld),
  .res_vld(res_vld), .res_hit(res_hit), .res_bank(res_bank),
  .res_gid(res_gid), .res_ilv(res_ilv), .res_size(res_size)
);

// File: tb/bank_decode_tb.sv
module bank_decode_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  port_id = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [30:0] cfg_data = '0;
  logic        lkp_vld = 1'b0;
  logic [42:0] lkp_addr = '0;
  logic        res_vld, res_hit;
  logic [1:0]  res_bank;
  logic [6:0]  res_gid;
  logic [4:0]  res_ilv;
  logic [42:0] res_base, res_size;

  bank_decode u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [30:0] m_reg [4];
  bit          e_hit = 0;
  int          e_bank = 0, e_gid = 0, e_ilv = 0;
  logic [63:0] e_base = 0, e_size = 0;

  function automatic logic [30:0] mk(bit en, int um, int uk, int lm, int lk);
    return {en, 11'(um), 11'(uk), 4'(lm), 4'(lk)};
  endfunction

  function automatic logic [42:0] ad(int up, int lo);
    return (43'(up) << 32) | (43'(lo) << 6);
  endfunction

  function automatic int ilv_of(int lk);
    case (lk)
      15: return 1;
      14: return 2;
      12: return 4;
      8:  return 8;
      0:  return 16;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input int idx, input logic [30:0] wd,
                      input bit rq, input logic [42:0] a, input string tag);
    cfg_we = we; cfg_idx = 2'(idx); cfg_data = wd;
    lkp_vld = rq; lkp_addr = a;
    if (rq) begin
      int up = int'(a[42:32]);
      int lo = int'(a[9:6]);
      e_hit = 0; e_bank = 0; e_gid = 0; e_ilv = 0; e_base = 0; e_size = 0;
      for (int b = 0; b < 4; b++) begin
        int um = int'(m_reg[b][29:19]);
        int uk = int'(m_reg[b][18:8]);
        int lm = int'(m_reg[b][7:4]);
        int lk = int'(m_reg[b][3:0]);
        if (!e_hit && m_reg[b][30] && (((up ^ um) & ~uk) == 0) && (((lo ^ lm) & ~lk) == 0)) begin
          e_hit  = 1;
          e_bank = b;
          e_gid  = 4 * int'(port_id) + b;
          e_ilv  = ilv_of(lk);
          e_base = 64'(um & ~uk & 2047) << 32;
          e_size = (64'((uk % 1024) + 1) << 32) / 64'(e_ilv);
        end
      end
    end
    @(posedge clk);
    if (we) m_reg[idx] = wd;
    @(negedge clk);
    cfg_we = 1'b0; lkp_vld = 1'b0;
    chk(tag, "vld", 64'(res_vld), 64'(rq));
    chk(tag, "hit", 64'(res_hit), 64'(e_hit));
    chk(tag, "bank", 64'(res_bank), 64'(e_bank));
    chk(tag, "gid", 64'(res_gid), 64'(e_gid));
    chk(tag, "ilv", 64'(res_ilv), 64'(e_ilv));
    chk(tag, "base", 64'(res_base), e_base);
    chk(tag, "size", 64'(res_size), e_size);
  endtask

  task automatic wr(input int idx, input logic [30:0] wd, input string tag);
    step(1, idx, wd, 0, '0, tag);
  endtask

  task automatic look(input logic [42:0] a, input string tag);
    step(0, 0, '0, 1, a, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset vld", 64'(res_vld), 0);
    chk("R1", "reset hit", 64'(res_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    look(ad(0, 0), "R1");
    look(ad(11'h7ff, 15), "R1");

    port_id = 5'd3;
    wr(0, mk(1, 5, 0, 3, 0), "R4");
    look(ad(5, 3), "R4");
    look(ad(5, 2), "R4");
    look(ad(4, 3), "R3");
    step(0, 0, '0, 0, '0, "R10");
    step(0, 0, '0, 0, '0, "R10");

    wr(1, mk(1, 8, 3, 9, 15), "R3");
    look(ad(11, 0), "R3");
    look(ad(10, 7), "R3");
    look(ad(12, 7), "R3");

    wr(2, mk(0, 5, 0, 3, 0), "R2");
    wr(0, mk(0, 5, 0, 3, 0), "R2");
    look(ad(5, 3), "R2");
    wr(3, mk(1, 5, 0, 3, 0), "R5");
    look(ad(5, 3), "R5");
    wr(2, mk(1, 4, 1, 2, 14), "R5");
    look(ad(5, 3), "R5");
    look(ad(5, 2), "R6");

    wr(2, mk(1, 20, 0, 0, 12), "R6");
    look(ad(20, 1), "R6");
    wr(2, mk(1, 20, 0, 0, 8), "R6");
    look(ad(20, 5), "R6");
    wr(2, mk(1, 20, 0, 0, 5), "R6");
    look(ad(20, 0), "R6");
    look(ad(20, 2), "R6");

    wr(0, mk(1, 11'h7ff, 11'h7ff, 0, 15), "R8");
    look(ad(0, 0), "R8");
    wr(0, mk(1, 11'h7ff, 11'h3ff, 0, 14), "R8");
    look(ad(11'h400, 1), "R7");
    wr(0, mk(1, 11'h6f0, 11'h00f, 0, 15), "R7");
    look(ad(11'h6f3, 9), "R7");

    step(1, 0, mk(0, 0, 0, 0, 0), 1, ad(11'h6f3, 9), "R11");
    look(ad(11'h6f3, 9), "R11");

    port_id = 5'd31;
    @(negedge clk);
    look(ad(20, 0), "R9");
    look(ad(8, 4), "R9");

    for (int k = 0; k < 300; k++) begin
      if (k % 3 == 0)
        step(1, int'($urandom_range(0, 3)),
             mk($urandom_range(0, 3) != 0, int'($urandom_range(0, 15)), int'($urandom_range(0, 2047)) & 11'h40f,
                int'($urandom_range(0, 15)), int'($urandom_range(0, 15))),
             $urandom_range(0, 1) == 1, ad(int'($urandom_range(0, 15)), int'($urandom_range(0, 15))), "R5");
      else
        step(0, 0, '0, $urandom_range(0, 3) != 0,
             ad(int'($urandom_range(0, 15)), int'($urandom_range(0, 15))), "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule